// File: doc/BRIEF.md
# UART control register file with Wishbone slave port

This block is the software-visible control store of a small UART peripheral. A processor reaches it over a 32-bit Wishbone classic slave port. It holds five word-aligned registers: the operating clock frequency, the last received byte, the byte to send, a receive-interrupt enable and a transmit-go flag. The serializer, the deserializer and the baud divider sit outside this block. They connect to it through plain signals: the frequency, the transmit byte, the enable and the go flag are driven out, and the received byte and a transmit-done clear come in.

Two fields have side effects. A bus read of the receive register produces a one-cycle "byte taken" pulse, which the receiver uses to drop its interrupt. The transmit-go flag is set by software and cleared by hardware when the frame is done. Software polls the flag until it reads 0. Requests reach the register logic only when the upper 24 address bits fall inside the block's window. Any other request is dropped before it reaches the register logic.

Top module: `uart_csr_wb`

## Requirements
- R1: After the active-low asynchronous reset, freq_o is 1000000, tx_byte_o is 0, irq_en_o is 1, tx_go_o is 0 and wb_ack_o is 0.
- R2: Each gated cycle-and-strobe request gets wb_ack_o high for exactly one clock, in the clock after the request is first seen. wb_dat_o is valid in that ack clock. wb_stall_o, wb_err_o and wb_rty_o stay 0.
- R3: A request whose address bits [31:8] differ from 0x300000 gets no ack and changes no register.
- R4: Offset 0x00 is the 32-bit read/write frequency register. Write byte lane n (wb_sel_i[n]) updates only bits [8n+7:8n].
- R5: Offset 0x04 reads rx_byte_i in bits [7:0] with bits [31:8] as 0. Writes to it have no effect on any register.
- R6: rx_taken_o is a one-clock pulse that is high only in the ack clock of a read of offset 0x04. A write to 0x04 or a read of any other offset gives no pulse.
- R7: Offset 0x08 holds the read/write transmit byte in bits [7:0], driven on tx_byte_o. Bits [31:8] read 0 and ignore writes.
- R8: Offset 0x0C bit 0 is the read/write interrupt enable, driven on irq_en_o. Bits [31:1] read 0.
- R9: Offset 0x10 bit 0 is the transmit-go flag. Writing 1 sets it and writing 0 clears it. A high tx_go_clr_i forces it to 0 on the next edge, and this wins over a software write of 1 in the same clock.
- R10: Offsets 0x14, 0x18 and 0x1C are acknowledged, read 0 and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when 1, read when 0 |
| wb_adr_i | input | 32 | Full byte address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte lane selects |
| wb_ack_o | output | 1 | Transfer acknowledge |
| wb_err_o | output | 1 | Error, always 0 |
| wb_rty_o | output | 1 | Retry, always 0 |
| wb_stall_o | output | 1 | Stall, always 0 |
| wb_dat_o | output | 32 | Read data, valid with ack |
| freq_o | output | 32 | Clock frequency value |
| rx_byte_i | input | 8 | Byte from the receiver |
| rx_taken_o | output | 1 | Pulse: receive register was read |
| tx_byte_o | output | 8 | Byte for the transmitter |
| irq_en_o | output | 1 | Receive interrupt enable |
| tx_go_clr_i | input | 1 | Transmitter done, clears the go flag |
| tx_go_o | output | 1 | Transmit-go flag |

## Verification
A corrupted field value shows up on its output pin at the next edge after the faulty write. It also shows up on wb_dat_o in the ack clock of the next read of that offset. A broken ack state shows up within one or two clocks as a missing ack or an ack that lasts two clocks, and a hung transfer follows from it. A wrong decode writes the wrong field. Its effect appears on another field's output pin, or in the read-back of an offset that should hold its value.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int DW        = 32;
  localparam int AW        = 32;
  localparam int LOC_AW    = 5;
  localparam int IDX_W     = LOC_AW - 2;
  localparam int WIN_W     = AW - 8;
  localparam int FREQ_W    = 32;
  localparam int BYTE_W    = 8;

  typedef enum logic [IDX_W-1:0] {
    IDX_FREQ  = 3'd0,
    IDX_RX    = 3'd1,
    IDX_TX    = 3'd2,
    IDX_IRQEN = 3'd3,
    IDX_GO    = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/wb_window_gate.sv
module wb_window_gate #(
  parameter int AW = 32,
  parameter int LOW_W = 8,
  parameter logic [AW-LOW_W-1:0] WINDOW = '0
) (
  input  logic [AW-LOW_W-1:0] adr_hi_i,
  input  logic                cyc_i,
  input  logic                stb_i,
  output logic                req_o
);
  always_comb req_o = cyc_i && stb_i && (adr_hi_i == WINDOW);
endmodule

// File: rtl/csr_wb_slave.sv
module csr_wb_slave #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_stb_o,
  output logic          rd_stb_o,
  output logic          ack_o,
  output logic [DW-1:0] dat_o
);
  logic ack_q;
  logic [DW-1:0] dat_q;
  logic first;

  // a request is served once; the ack clock blocks a second service
  assign first    = req_i && !ack_q;
  assign wr_stb_o = first && we_i;
  assign rd_stb_o = first && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= first;
      if (rd_stb_o) dat_q <= rd_data_i;
      else if (first) dat_q <= '0;
    end
  end

  assign ack_o = ack_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/csr_field.sv
module csr_field #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0,
  parameter bit HW_CLR = 1'b0,
  localparam int LANES = (W + 7) / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  input  logic [W-1:0]     wd_i,
  input  logic             clr_i,
  output logic [W-1:0]     q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= RST;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (HW_CLR && clr_i) q_o[i] <= 1'b0;   // hardware clear wins
        else if (we_i && be_i[i/8]) q_o[i] <= wd_i[i];
      end
    end
  end
endmodule

// File: rtl/uart_csr_wb.sv
module uart_csr_wb
  import uart_csr_pkg::*;
#(
  parameter logic [WIN_W-1:0] WINDOW = 24'h300000,
  parameter logic [FREQ_W-1:0] FREQ_RST = 32'd1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [AW-1:0]     wb_adr_i,
  input  logic [DW-1:0]     wb_dat_i,
  input  logic [DW/8-1:0]   wb_sel_i,
  output logic              wb_ack_o,
  output logic              wb_err_o,
  output logic              wb_rty_o,
  output logic              wb_stall_o,
  output logic [DW-1:0]     wb_dat_o,
  output logic [FREQ_W-1:0] freq_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              rx_taken_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              irq_en_o,
  input  logic              tx_go_clr_i,
  output logic              tx_go_o
);
  logic req, wr_stb, rd_stb;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0] rd_mux;
  logic taken_q;
  logic unused_adr;

  assign idx        = wb_adr_i[LOC_AW-1:2];
  assign unused_adr = ^{wb_adr_i[7:LOC_AW], wb_adr_i[1:0]};

  wb_window_gate #(.AW(AW), .LOW_W(8), .WINDOW(WINDOW)) gate_i (
    .adr_hi_i(wb_adr_i[AW-1:8]), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .req_o(req)
  );

  csr_wb_slave #(.DW(DW)) slv_i (
    .clk_i, .rst_ni, .req_i(req), .we_i(wb_we_i), .rd_data_i(rd_mux),
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb), .ack_o(wb_ack_o), .dat_o(wb_dat_o)
  );

  csr_field #(.W(FREQ_W), .RST(FREQ_RST)) f_freq (
    .clk_i, .rst_ni, .we_i(wr_stb && idx == IDX_FREQ), .be_i(wb_sel_i),
    .wd_i(wb_dat_i[FREQ_W-1:0]), .clr_i(1'b0), .q_o(freq_o)
  );

  csr_field #(.W(BYTE_W), .RST('0)) f_tx (
    .clk_i, .rst_ni, .we_i(wr_stb && idx == IDX_TX), .be_i(wb_sel_i[0]),
    .wd_i(wb_dat_i[BYTE_W-1:0]), .clr_i(1'b0), .q_o(tx_byte_o)
  );

  csr_field #(.W(1), .RST(1'b1)) f_irq (
    .clk_i, .rst_ni, .we_i(wr_stb && idx == IDX_IRQEN), .be_i(wb_sel_i[0]),
    .wd_i(wb_dat_i[0]), .clr_i(1'b0), .q_o(irq_en_o)
  );

  csr_field #(.W(1), .RST(1'b0), .HW_CLR(1'b1)) f_go (
    .clk_i, .rst_ni, .we_i(wr_stb && idx == IDX_GO), .be_i(wb_sel_i[0]),
    .wd_i(wb_dat_i[0]), .clr_i(tx_go_clr_i), .q_o(tx_go_o)
  );

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_FREQ:  rd_mux[FREQ_W-1:0] = freq_o;
      IDX_RX:    rd_mux[BYTE_W-1:0] = rx_byte_i;
      IDX_TX:    rd_mux[BYTE_W-1:0] = tx_byte_o;
      IDX_IRQEN: rd_mux[0] = irq_en_o;
      IDX_GO:    rd_mux[0] = tx_go_o;
      default:   rd_mux = '0;
    endcase
  end

  // pulse lines up with the ack clock of the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taken_q <= 1'b0;
    else         taken_q <= rd_stb && idx == IDX_RX;
  end

  assign rx_taken_o = taken_q;
  assign wb_err_o   = 1'b0;
  assign wb_rty_o   = 1'b0;
  assign wb_stall_o = 1'b0;
endmodule

// File: rtl/uart_csr_wb_chk.sv
module uart_csr_wb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wb_cyc_i,
  input logic        wb_stb_i,
  input logic        wb_we_i,
  input logic [31:0] wb_adr_i,
  input logic        wb_ack_o,
  input logic [31:0] wb_dat_o,
  input logic [31:0] freq_o,
  input logic        rx_taken_o,
  input logic        tx_go_clr_i,
  input logic        tx_go_o
);
  logic in_win;
  assign in_win = wb_adr_i[31:8] == 24'h300000;

  // R2
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);

  // R3
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i && in_win));

  // R6
  taken_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_taken_o |-> wb_ack_o && $past(!wb_we_i && wb_adr_i[4:2] == 3'd1));

  // R9
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_go_clr_i) |-> !tx_go_o);

  // R5
  rx_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o && $past(!wb_we_i && wb_adr_i[4:2] == 3'd1)) |-> wb_dat_o[31:8] == 24'h0);

  // R4
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(wb_cyc_i && wb_stb_i && in_win && wb_we_i && !wb_ack_o && wb_adr_i[4:2] == 3'd0))
    |-> $stable(freq_o));
endmodule

bind uart_csr_wb uart_csr_wb_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
  .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_ack_o(wb_ack_o), .wb_dat_o(wb_dat_o),
  .freq_o(freq_o), .rx_taken_o(rx_taken_o), .tx_go_clr_i(tx_go_clr_i), .tx_go_o(tx_go_o)
);

// File: tb/uart_csr_wb_tb_top.sv
module uart_csr_wb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [31:0] adr = '0, wdat = '0;
  logic [3:0] sel = '0;
  logic ack, err, rty, stall, taken, irq_en, go;
  logic [31:0] rdat, freq;
  logic [7:0] rx_byte = 8'h00, tx_byte;
  logic go_clr = 1'b0;
  int n_chk = 0, n_fail = 0, taken_cnt = 0;
  bit done = 0;

  localparam logic [31:0] BASE = 32'h3000_0000;

  always #4 clk = ~clk;

  uart_csr_wb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel), .wb_ack_o(ack), .wb_err_o(err),
    .wb_rty_o(rty), .wb_stall_o(stall), .wb_dat_o(rdat), .freq_o(freq),
    .rx_byte_i(rx_byte), .rx_taken_o(taken), .tx_byte_o(tx_byte), .irq_en_o(irq_en),
    .tx_go_clr_i(go_clr), .tx_go_o(go)
  );

  always @(negedge clk) if (taken) taken_cnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [31:0] d, input logic [3:0] s,
                      output logic [31:0] rd, output logic acked, output int tk, output int acks);
    int t0;
    t0 = taken_cnt;
    acked = 1'b0; rd = '0; acks = 0;
    @(negedge clk);
    adr = a; we = w; wdat = d; sel = s; cyc = 1'b1; stb = 1'b1;
    for (int n = 0; n < 6 && !acked; n++) begin
      @(negedge clk);
      if (ack) begin acked = 1'b1; rd = rdat; acks++; end
    end
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    if (ack) acks++;
    tk = taken_cnt - t0;
  endtask

  task automatic rd32(input logic [31:0] a, output logic [31:0] v);
    logic k; int t, c;
    xfer(a, 1'b0, '0, 4'hF, v, k, t, c);
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] v; logic k; int t, c;
    xfer(a, 1'b1, d, s, v, k, t, c);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(freq == 32'd1000000, "R1 freq reset", freq, 32'd1000000);
    check(tx_byte == 8'h00, "R1 tx reset", {24'h0, tx_byte}, 32'h0);
    check(irq_en == 1'b1, "R1 irq_en reset", {31'h0, irq_en}, 32'h1);
    check(go == 1'b0 && ack == 1'b0, "R1 go/ack reset", {30'h0, go, ack}, 32'h0);
  endtask

  task automatic t_ack;
    logic [31:0] v; logic k; int t, c;
    xfer(BASE, 1'b0, '0, 4'hF, v, k, t, c);
    check(k && c == 1, "R2 single ack", c, 1);
    check(v == 32'd1000000, "R2 data with ack", v, 32'd1000000);
    check(!err && !rty && !stall, "R2 err/rty/stall", {29'h0, err, rty, stall}, 32'h0);
  endtask

  task automatic t_freq_lanes;
    logic [31:0] v;
    wr32(BASE, 32'hAABBCCDD, 4'hF);
    rd32(BASE, v);
    check(v == 32'hAABBCCDD && freq == 32'hAABBCCDD, "R4 full write", v, 32'hAABBCCDD);
    wr32(BASE, 32'h11223344, 4'b0101);
    rd32(BASE, v);
    check(v == 32'hAA22CC44, "R4 lanes 0,2", v, 32'hAA22CC44);
    wr32(BASE, 32'h55667788, 4'b1000);
    check(freq == 32'h5522CC44, "R4 lane 3", freq, 32'h5522CC44);
  endtask

  task automatic t_rx;
    logic [31:0] v; logic k; int t, c;
    rx_byte = 8'hA5;
    xfer(BASE + 4, 1'b0, '0, 4'hF, v, k, t, c);
    check(v == 32'h000000A5, "R5 rx read", v, 32'hA5);
    check(t == 1, "R6 pulse on rx read", t, 1);
    xfer(BASE + 4, 1'b1, 32'hFFFFFFFF, 4'hF, v, k, t, c);
    check(t == 0, "R6 no pulse on rx write", t, 0);
    check(freq == 32'h5522CC44 && tx_byte == 8'h00 && irq_en && !go, "R5 write ignored",
          freq, 32'h5522CC44);
    rx_byte = 8'h3C;
    xfer(BASE + 4, 1'b0, '0, 4'hF, v, k, t, c);
    check(v == 32'h0000003C, "R5 rx follows input", v, 32'h3C);
    xfer(BASE + 8, 1'b0, '0, 4'hF, v, k, t, c);
    check(t == 0, "R6 no pulse on other read", t, 0);
  endtask

  task automatic t_tx_irq;
    logic [31:0] v;
    wr32(BASE + 8, 32'hDEADBE5A, 4'hF);
    rd32(BASE + 8, v);
    check(v == 32'h0000005A && tx_byte == 8'h5A, "R7 tx rw", v, 32'h5A);
    wr32(BASE + 8, 32'h000000FF, 4'b1110);
    check(tx_byte == 8'h5A, "R7 lane0 needed", {24'h0, tx_byte}, 32'h5A);
    wr32(BASE + 12, 32'hFFFFFFFE, 4'hF);
    rd32(BASE + 12, v);
    check(v == 32'h0 && !irq_en, "R8 irq_en clear", v, 32'h0);
    wr32(BASE + 12, 32'hFFFFFFFF, 4'hF);
    rd32(BASE + 12, v);
    check(v == 32'h1 && irq_en, "R8 irq_en set, upper zero", v, 32'h1);
  endtask

  task automatic t_go;
    logic [31:0] v;
    wr32(BASE + 16, 32'h1, 4'h1);
    check(go == 1'b1, "R9 set by write", {31'h0, go}, 32'h1);
    rd32(BASE + 16, v);
    check(v == 32'h1, "R9 read set", v, 32'h1);
    @(negedge clk); go_clr = 1'b1;
    @(negedge clk); go_clr = 1'b0;
    check(go == 1'b0, "R9 hw clear", {31'h0, go}, 32'h0);
    rd32(BASE + 16, v);
    check(v == 32'h0, "R9 poll reads 0", v, 32'h0);
    go_clr = 1'b1;
    wr32(BASE + 16, 32'h1, 4'h1);
    go_clr = 1'b0;
    check(go == 1'b0, "R9 clear wins", {31'h0, go}, 32'h0);
    wr32(BASE + 16, 32'h1, 4'h1);
    wr32(BASE + 16, 32'h0, 4'h1);
    check(go == 1'b0, "R9 sw write 0", {31'h0, go}, 32'h0);
  endtask

  task automatic t_window;
    logic [31:0] v; logic k; int t, c;
    xfer(32'h3000_0108, 1'b1, 32'h77, 4'hF, v, k, t, c);
    check(!k && c == 0, "R3 no ack outside", c, 0);
    check(tx_byte == 8'h5A, "R3 no write outside", {24'h0, tx_byte}, 32'h5A);
    xfer(32'h4000_0000, 1'b1, 32'h0, 4'hF, v, k, t, c);
    check(!k && freq == 32'h5522CC44, "R3 far address", freq, 32'h5522CC44);
  endtask

  task automatic t_unmapped;
    logic [31:0] v; logic k; int t, c;
    for (int o = 5; o < 8; o++) begin
      xfer(BASE + o * 4, 1'b1, 32'hFFFFFFFF, 4'hF, v, k, t, c);
      check(k, "R10 write acked", {31'h0, k}, 32'h1);
      xfer(BASE + o * 4, 1'b0, '0, 4'hF, v, k, t, c);
      check(k && v == 32'h0, "R10 reads zero", v, 32'h0);
    end
    check(freq == 32'h5522CC44 && tx_byte == 8'h5A && irq_en && !go, "R10 no write",
          freq, 32'h5522CC44);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ack();
    t_freq_lanes();
    t_rx();
    t_tx_irq();
    t_go();
    t_window();
    t_unmapped();
    finish_run();
  end
endmodule